// File: doc/BRIEF.md
# Two-Plane Keyed Alpha Blender

This block merges a graphics plane and a video overlay plane into one RGB stream, one pixel per clock. Both planes arrive as 32-bit ARGB words that share a single valid strobe. A programmable plane order decides which plane lies underneath and which lies on top. Each plane has its own settings:

- a blend mode: opaque, a constant global alpha, or the alpha carried in its own pixels;
- an 8-bit global alpha value;
- a 24-bit colour key with a per-bit compare mask.

The key compare can be switched off. When it is on, it looks at either the plane's own pixel or the colour already built up beneath it. A key hit makes that plane fully transparent at that position.

Blending runs in two registered stages. The lower plane is first composited over a black background using its own mode and key, and in that case the "previous" colour is black. The upper plane is then composited over that result. The output and its valid strobe leave the block exactly two clocks after the inputs.

Pixel layout on both inputs: bits 31:24 alpha, 23:16 red, 15:8 green, 7:0 blue. Key, mask and output use bits 23:0 in the same RGB order. The configuration inputs are expected to be held steady while pixels are in flight.

Top module: `plane_keyblend`

## Requirements
- R1: After reset `out_valid` and `out_rgb` are 0, and the plane order is graphics at the bottom and video on top.
- R2: `out_valid` repeats `in_valid` exactly two clocks later, and `out_rgb` in that cycle is the result for the pixels presented with it; back-to-back pixels stream at one per clock.
- R3: Blend mode codes 0 and 3 make a plane opaque (alpha 255), so with no key hit the top plane's RGB appears unchanged.
- R4: Blend mode code 1 uses the plane's global alpha `a`, and each channel is (a*top + (255-a)*below + 127)/255, rounded down.
- R5: Blend mode code 2 uses bits 31:24 of that plane's own pixel as `a` and ignores the global alpha.
- R6: The bottom plane is blended over black with its own mode, so a bottom plane with alpha `a` under a transparent top yields (a*c + 127)/255 per channel.
- R7: With the key enabled and the source bit 0, the compare uses the colour beneath the plane: the bottom-stage result for the top plane, and black for the bottom plane. A hit forces the alpha of that plane to 0.
- R8: With the key enabled and the source bit 1, the compare uses the plane's own RGB, and a hit forces its alpha to 0.
- R9: Only bits set in the plane's key mask take part in the compare, so an all-zero mask always hits while the key is enabled.
- R10: With the key enable bit 0, the key and mask have no effect even when the colours are equal.
- R11: A pulse on `ord_we` with `ord_bottom` different from `ord_top` loads the order (0 = graphics, 1 = video), and the top-plane settings follow the plane now on top.
- R12: A pulse on `ord_we` with `ord_bottom` equal to `ord_top` is rejected and leaves the order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ord_we | input | 1 | Plane-order write strobe |
| ord_bottom | input | 1 | Plane for the bottom position (0 graphics, 1 video) |
| ord_top | input | 1 | Plane for the top position (0 graphics, 1 video) |
| gfx_mode | input | 2 | Graphics blend mode (0/3 opaque, 1 global, 2 per-pixel) |
| gfx_galpha | input | 8 | Graphics global alpha |
| gfx_key | input | 24 | Graphics colour key |
| gfx_kmask | input | 24 | Graphics key compare mask |
| gfx_key_en | input | 1 | Graphics key enable |
| gfx_key_src | input | 1 | Graphics key source (0 beneath, 1 own pixel) |
| vid_mode | input | 2 | Video blend mode |
| vid_galpha | input | 8 | Video global alpha |
| vid_key | input | 24 | Video colour key |
| vid_kmask | input | 24 | Video key compare mask |
| vid_key_en | input | 1 | Video key enable |
| vid_key_src | input | 1 | Video key source |
| in_valid | input | 1 | Input pixel strobe |
| gfx_px | input | 32 | Graphics ARGB pixel |
| vid_px | input | 32 | Video ARGB pixel |
| out_valid | output | 1 | Output pixel strobe |
| out_rgb | output | 24 | Blended RGB pixel |

## Verification
A wrongly held plane-order bit swaps which plane's settings apply. It shows on the first pixel that follows, two clocks after that pixel enters, as the wrong plane's colour on `out_rgb`. A corrupt bottom-stage register shows up one clock later in the output, both as a wrong colour and as a wrong key decision for a top plane keyed against the colour beneath it. A valid bit lost or duplicated in the pipeline appears as an `out_valid` pulse that does not sit exactly two clocks after `in_valid`.

// File: rtl/plane_keyblend.sv
module plane_keyblend #(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ord_we,
  input  logic            ord_bottom,
  input  logic            ord_top,
  input  logic [1:0]      gfx_mode,
  input  logic [CW-1:0]   gfx_galpha,
  input  logic [3*CW-1:0] gfx_key,
  input  logic [3*CW-1:0] gfx_kmask,
  input  logic            gfx_key_en,
  input  logic            gfx_key_src,
  input  logic [1:0]      vid_mode,
  input  logic [CW-1:0]   vid_galpha,
  input  logic [3*CW-1:0] vid_key,
  input  logic [3*CW-1:0] vid_kmask,
  input  logic            vid_key_en,
  input  logic            vid_key_src,
  input  logic            in_valid,
  input  logic [4*CW-1:0] gfx_px,
  input  logic [4*CW-1:0] vid_px,
  output logic            out_valid,
  output logic [3*CW-1:0] out_rgb
);
  localparam int KW = 3 * CW;
  localparam int PW = 4 * CW;
  localparam logic [31:0] AMAX = (32'd1 << CW) - 32'd1;

  function automatic logic khit(input logic [KW-1:0] cur, prv, key, msk,
                                input logic en, src);
    return en && ((((src ? cur : prv) ^ key) & msk) == '0);
  endfunction

  function automatic logic [CW-1:0] pick(input logic [1:0] md,
                                         input logic [CW-1:0] ga, pa,
                                         input logic hit);
    if (hit) return '0;
    case (md)
      2'd1:    return ga;
      2'd2:    return pa;
      default: return '1;
    endcase
  endfunction

  function automatic logic [KW-1:0] mix(input logic [CW-1:0] a,
                                        input logic [KW-1:0] t, b);
    logic [KW-1:0] r;
    logic [31:0] acc;
    for (int i = 0; i < 3; i++) begin
      acc = 32'(a) * 32'(t[i*CW +: CW]) + (AMAX - 32'(a)) * 32'(b[i*CW +: CW])
            + (AMAX >> 1);
      r[i*CW +: CW] = CW'(acc / AMAX);
    end
    return r;
  endfunction

  logic vid_top;

  always_ff @(posedge clk) begin
    if (!rst_n)                            vid_top <= 1'b1;
    else if (ord_we && ord_bottom != ord_top) vid_top <= ord_top;
  end

  logic [PW-1:0] b_px, t_px_in;
  logic [1:0]    b_mode, t_mode;
  logic [CW-1:0] b_ga, t_ga;
  logic [KW-1:0] b_key, b_msk, t_key, t_msk;
  logic          b_en, b_src, t_en, t_src;

  assign b_px    = vid_top ? gfx_px      : vid_px;
  assign t_px_in = vid_top ? vid_px      : gfx_px;
  assign b_mode  = vid_top ? gfx_mode    : vid_mode;
  assign t_mode  = vid_top ? vid_mode    : gfx_mode;
  assign b_ga    = vid_top ? gfx_galpha  : vid_galpha;
  assign t_ga    = vid_top ? vid_galpha  : gfx_galpha;
  assign b_key   = vid_top ? gfx_key     : vid_key;
  assign t_key   = vid_top ? vid_key     : gfx_key;
  assign b_msk   = vid_top ? gfx_kmask   : vid_kmask;
  assign t_msk   = vid_top ? vid_kmask   : gfx_kmask;
  assign b_en    = vid_top ? gfx_key_en  : vid_key_en;
  assign t_en    = vid_top ? vid_key_en  : gfx_key_en;
  assign b_src   = vid_top ? gfx_key_src : vid_key_src;
  assign t_src   = vid_top ? vid_key_src : gfx_key_src;

  logic          b_hit;
  logic [CW-1:0] b_alpha;
  logic [KW-1:0] b_rgb;

  assign b_hit   = khit(b_px[KW-1:0], '0, b_key, b_msk, b_en, b_src);
  assign b_alpha = pick(b_mode, b_ga, b_px[PW-1:KW], b_hit);
  assign b_rgb   = mix(b_alpha, b_px[KW-1:0], '0);

  logic          s1_valid;
  logic [KW-1:0] s1_bot;
  logic [PW-1:0] s1_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_bot   <= '0;
      s1_top   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_bot   <= b_rgb;
      s1_top   <= t_px_in;
    end
  end

  logic [KW-1:0] s1_top_rgb;
  logic          t_hit;
  logic [CW-1:0] t_alpha;

  assign s1_top_rgb = s1_top[KW-1:0];
  assign t_hit      = khit(s1_top_rgb, s1_bot, t_key, t_msk, t_en, t_src);
  assign t_alpha    = pick(t_mode, t_ga, s1_top[PW-1:KW], t_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_rgb   <= mix(t_alpha, s1_top_rgb, s1_bot);
    end
  end
endmodule

module plane_keyblend_chk #(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic [3*CW-1:0] out_rgb,
  input logic            ord_we,
  input logic            ord_bottom,
  input logic            ord_top,
  input logic            vid_top,
  input logic            s1_valid,
  input logic [3*CW-1:0] s1_bot,
  input logic [3*CW-1:0] s1_top_rgb,
  input logic [CW-1:0]   t_alpha,
  input logic            t_hit
);
  AST_VALID_TWO_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid); // R2
  AST_IDLE_TWO_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid); // R2
  AST_OPAQUE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && (&t_alpha) |=> out_rgb == $past(s1_top_rgb)); // R3
  AST_KEY_HIT_SHOWS_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && t_hit |=> out_rgb == $past(s1_bot)); // R7
  AST_ORDER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ord_we && (ord_bottom != ord_top) |=> vid_top == $past(ord_top)); // R11
  AST_ORDER_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ord_we && (ord_bottom == ord_top) |=> $stable(vid_top)); // R12
endmodule

bind plane_keyblend plane_keyblend_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_rgb(out_rgb), .ord_we(ord_we), .ord_bottom(ord_bottom), .ord_top(ord_top),
  .vid_top(vid_top), .s1_valid(s1_valid), .s1_bot(s1_bot),
  .s1_top_rgb(s1_top_rgb), .t_alpha(t_alpha), .t_hit(t_hit)
);

// File: tb/test_plane_keyblend.sv
module test_plane_keyblend;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ord_we = 1'b0, ord_bottom = 1'b0, ord_top = 1'b1;
  logic [1:0]  gfx_mode = 2'd0, vid_mode = 2'd0;
  logic [7:0]  gfx_galpha = 8'd0, vid_galpha = 8'd0;
  logic [23:0] gfx_key = '0, vid_key = '0, gfx_kmask = '1, vid_kmask = '1;
  logic gfx_key_en = 1'b0, gfx_key_src = 1'b0, vid_key_en = 1'b0, vid_key_src = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] gfx_px = '0, vid_px = '0;
  logic out_valid;
  logic [23:0] out_rgb;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plane_keyblend i_plane_keyblend (
    .clk(clk), .rst_n(rst_n), .ord_we(ord_we), .ord_bottom(ord_bottom), .ord_top(ord_top),
    .gfx_mode(gfx_mode), .gfx_galpha(gfx_galpha), .gfx_key(gfx_key), .gfx_kmask(gfx_kmask),
    .gfx_key_en(gfx_key_en), .gfx_key_src(gfx_key_src),
    .vid_mode(vid_mode), .vid_galpha(vid_galpha), .vid_key(vid_key), .vid_kmask(vid_kmask),
    .vid_key_en(vid_key_en), .vid_key_src(vid_key_src),
    .in_valid(in_valid), .gfx_px(gfx_px), .vid_px(vid_px),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );

  function automatic logic [23:0] blend(input int a, input logic [23:0] t, input logic [23:0] b);
    logic [23:0] r;
    for (int c = 0; c < 3; c++) begin
      int tc = int'(t[8*c +: 8]);
      int bc = int'(b[8*c +: 8]);
      r[8*c +: 8] = 8'((a * tc + (255 - a) * bc + 127) / 255);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_one(input string tag, input logic [31:0] g, input logic [31:0] v,
                         input logic [23:0] exp);
    @(negedge clk);
    gfx_px = g; vid_px = v; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk(tag, {8'd0, out_rgb}, {8'd0, exp});
  endtask

  task automatic set_order(input logic b, input logic t);
    @(negedge clk);
    ord_we = 1'b1; ord_bottom = b; ord_top = t;
    @(negedge clk);
    ord_we = 1'b0;
  endtask

  task automatic clear_cfg;
    gfx_mode = 0; vid_mode = 0; gfx_galpha = 0; vid_galpha = 0;
    gfx_key_en = 0; vid_key_en = 0; gfx_key_src = 0; vid_key_src = 0;
    gfx_kmask = '1; vid_kmask = '1; gfx_key = '0; vid_key = '0;
  endtask

  task automatic t_reset;
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset rgb", {8'd0, out_rgb}, 32'd0);
    run_one("R1 default order video on top", 32'h00112233, 32'h00AABBCC, 24'hAABBCC);
  endtask

  task automatic t_stream;
    logic [31:0] gv [3] = '{32'h00010203, 32'h00040506, 32'h00070809};
    logic [31:0] vv [3] = '{32'h00A0A0A0, 32'h00B1B2B3, 32'h00C4C5C6};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2 && i < 5) begin
        chk("R2 stream valid", {31'd0, out_valid}, 32'd1);
        chk("R2 stream rgb", {8'd0, out_rgb}, {8'd0, vv[i-2][23:0]});
      end else begin
        chk("R2 stream idle", {31'd0, out_valid}, 32'd0);
      end
      if (i < 3) begin
        in_valid = 1'b1; gfx_px = gv[i]; vid_px = vv[i];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_modes;
    clear_cfg();
    vid_mode = 2'd3;
    run_one("R3 mode 3 opaque", 32'h00102030, 32'h80405060, 24'h405060);
    vid_mode = 2'd1; vid_galpha = 8'h40;
    run_one("R4 global alpha", 32'h00204060, 32'h00FF8000,
            blend(64, 24'hFF8000, 24'h204060));
    vid_mode = 2'd2; vid_galpha = 8'h10;
    run_one("R5 per-pixel alpha", 32'h00204060, 32'h80FF8000,
            blend(128, 24'hFF8000, 24'h204060));
    gfx_mode = 2'd1; gfx_galpha = 8'd128;
    run_one("R6 bottom over black", 32'h00C8640A, 32'h00FFFFFF,
            blend(128, 24'hC8640A, 24'h000000));
    clear_cfg();
  endtask

  task automatic t_keys;
    clear_cfg();
    vid_key_en = 1; vid_key_src = 0; vid_key = 24'h123456;
    run_one("R7 previous-source hit", 32'h00123456, 32'h00ABCDEF, 24'h123456);
    vid_key = 24'h123457;
    run_one("R7 previous-source miss", 32'h00123456, 32'h00ABCDEF, 24'hABCDEF);
    clear_cfg();
    gfx_key_en = 1; gfx_key = 24'h000000; vid_mode = 2'd2;
    run_one("R7 bottom keyed against black", 32'h00FFEEDD, 32'h00999999, 24'h000000);
    clear_cfg();
    vid_key_en = 1; vid_key_src = 1; vid_key = 24'hABCDEF;
    run_one("R8 current-source hit", 32'h00123456, 32'h00ABCDEF, 24'h123456);
    vid_key = 24'hABCDEE;
    run_one("R8 current-source miss", 32'h00123456, 32'h00ABCDEF, 24'hABCDEF);
    vid_kmask = 24'hFFFF00;
    run_one("R9 masked bits ignored", 32'h00123456, 32'h00ABCDEF, 24'h123456);
    vid_kmask = 24'h000000; vid_key = 24'h555555;
    run_one("R9 zero mask always hits", 32'h00123456, 32'h00ABCDEF, 24'h123456);
    vid_key_en = 0; vid_kmask = '1; vid_key = 24'hABCDEF;
    run_one("R10 key disabled", 32'h00123456, 32'h00ABCDEF, 24'hABCDEF);
    clear_cfg();
  endtask

  task automatic t_order;
    clear_cfg();
    set_order(1'b1, 1'b0);
    run_one("R11 graphics on top", 32'h00123456, 32'h00ABCDEF, 24'h123456);
    gfx_mode = 2'd1; gfx_galpha = 8'h80; vid_mode = 2'd1; vid_galpha = 8'hFF;
    run_one("R11 top settings follow graphics", 32'h00123456, 32'h00ABCDEF,
            blend(128, 24'h123456, 24'hABCDEF));
    clear_cfg();
    set_order(1'b1, 1'b1);
    run_one("R12 equal video rejected", 32'h00123456, 32'h00ABCDEF, 24'h123456);
    set_order(1'b0, 1'b0);
    run_one("R12 equal graphics rejected", 32'h00123456, 32'h00ABCDEF, 24'h123456);
    set_order(1'b0, 1'b1);
    run_one("R11 video back on top", 32'h00123456, 32'h00ABCDEF, 24'hABCDEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre();
  end

  task automatic t_reset_pre;
    chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stream();
    t_modes();
    t_keys();
    t_order();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule